// File: doc/BRIEF.md
# Angle Folding Front End

This block sits in front of a one-direction, shift-and-add vector rotator. It accepts a signed target angle on the full circle plus the two coordinates of the vector to be turned. In a single registered cycle it reduces the angle to a small unsigned residue in the range zero to one eighth of a half turn. It reports the quarter of the circle the angle came from, the one-eighth-of-a-half-turn slice inside that quarter, and whether the residue has to be applied backwards. The downstream rotator only ever has to handle the short residue. A later correction stage uses the quarter and slice codes to rebuild the true result by swapping, negating or scaling.

Angles use a fixed-point scale with 1.0 = 2^14, so a full turn is the constant 102943. The derived constants are rounded from that value as k·turn/16. A half-quarter (pi/8) is 6434, a quarter-half (pi/4) is 12868, 3pi/8 is 19302 and a quarter turn (pi/2) is 25736. The angle is first wrapped into [0, turn). It is then split into a quarter and an offset t in [0, 25736), and t is compared against the three slice boundaries. Only constant comparisons and subtractions are used.

Top module: `angle_fold_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output is cleared to zero at that edge.
- R2: Outputs change only at a rising edge. Each output reflects the inputs sampled at that same edge, so there is one cycle of latency.
- R3: A negative angle a in [-102943, 0) produces exactly the outputs of a + 102943.
- R4: quad_o is 0, 1, 2 or 3 when the wrapped angle lies in [0,25736), [25736,51472), [51472,77208) or [77208,102943). The offset t is the wrapped angle minus quad_o·25736.
- R5: dom_o is 0 for t<6434, with phi_o = t. It is 1 for 6434≤t<12868, with phi_o = 12868−t. It is 2 for 12868≤t<19302, with phi_o = t−12868. It is 3 otherwise, with phi_o = 25736−t.
- R6: phi_o never exceeds 6434, which fits the 13-bit phi_o field.
- R7: An angle exactly on a slice boundary goes to the higher slice. Angles at multiples of 12868 inside a quarter (t = 0 or t = 12868) give phi_o = 0. Slices 1 and 3 never give phi_o = 0.
- R8: dir_o is 1 exactly when dom_o is 1 or 3, meaning the residue is applied clockwise.
- R9: Inputs outside one turn wrap by whole turns. A value ≥102943 has 102943 removed, and a value below −102943 has 205886 added.
- R10: x_o and y_o carry x_i and y_i unchanged, with the same one-cycle latency as the angle results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ang_i | input | 18 | Signed target angle, 1.0 = 2^14 |
| x_i | input | 16 | Vector x coordinate |
| y_i | input | 16 | Vector y coordinate |
| phi_o | output | 13 | Folded unsigned residue angle |
| quad_o | output | 2 | Quarter of the circle, 0..3 |
| dom_o | output | 2 | Slice inside the first quarter, 0..3 |
| dir_o | output | 1 | 1 = apply residue clockwise |
| x_o | output | 16 | Registered x coordinate |
| y_o | output | 16 | Registered y coordinate |

## Verification
Every slice and quarter boundary is driven together with its immediate lower neighbour. This separates the higher-slice tie rule and the zero-residue points from an off-by-one comparator. Negative angles, and angles one full turn above or below the range, show whether the wrap step adds or removes the right multiple of a turn, independent of the fold. A coarse stride sweep across the entire 18-bit input range lands in every quarter and slice with irregular offsets. This exposes a wrong subtraction base or a swapped direction bit. The coordinates change on every vector, so a stale or crossed register path shows up.

// File: rtl/afu_pkg.sv
package afu_pkg;

   typedef enum logic [1:0] {
      SLICE_0 = 2'd0,
      SLICE_1 = 2'd1,
      SLICE_2 = 2'd2,
      SLICE_3 = 2'd3
   } slice_e;

   // k sixteenths of a full turn, rounded to nearest
   function automatic int turn_frac(input int turn, input int k);
      return (k * turn + 8) / 16;
   endfunction

endpackage

// File: rtl/afu_wrap.sv
module afu_wrap #(
   parameter int ANG_W = 18,
   parameter int WK    = 20,
   parameter int TURN  = 102943
) (
   input  logic signed [ANG_W-1:0] ang_i,
   output logic        [WK-1:0]    pos_o
);
   localparam logic signed [WK-1:0] K_TURN  = WK'(TURN);
   localparam logic signed [WK-1:0] K_NTURN = -K_TURN;
   localparam logic signed [WK-1:0] K_2TURN = WK'(2 * TURN);

   logic signed [WK-1:0] ext;
   logic signed [WK-1:0] wrapped;

   assign ext = {{(WK-ANG_W){ang_i[ANG_W-1]}}, ang_i};

   always_comb begin
      if (ext < K_NTURN)
         wrapped = ext + K_2TURN;
      else if (ext < 0)
         wrapped = ext + K_TURN;
      else if (ext >= K_TURN)
         wrapped = ext - K_TURN;
      else
         wrapped = ext;
   end

   assign pos_o = wrapped;

endmodule

// File: rtl/afu_quad.sv
module afu_quad #(
   parameter int WK  = 20,
   parameter int QTR = 25736
) (
   input  logic [WK-1:0] pos_i,
   output logic [1:0]    quad_o,
   output logic [WK-1:0] t_o
);
   localparam int NB = 3;

   logic [NB-1:0] ge;

   for (genvar k = 1; k <= NB; k++) begin : g_cmp
      localparam logic [WK-1:0] LIM = WK'(k * QTR);
      assign ge[k-1] = (pos_i >= LIM);
   end

   always_comb begin
      logic [WK-1:0] base;
      logic [1:0]    cnt;
      base = '0;
      cnt  = '0;
      for (int k = 0; k < NB; k++) begin
         if (ge[k]) begin
            base = WK'((k + 1) * QTR);
            cnt  = 2'(k + 1);
         end
      end
      quad_o = cnt;
      t_o    = pos_i - base;
   end

endmodule

// File: rtl/afu_dfold.sv
module afu_dfold
   import afu_pkg::*;
#(
   parameter int WK       = 20,
   parameter int PHI_W    = 13,
   parameter int EIGHTH   = 6434,
   parameter int QUARTER  = 12868,
   parameter int QTR      = 25736,
   parameter bit PAR_FOLD = 1'b1
) (
   input  logic [WK-1:0]    t_i,
   output slice_e           dom_o,
   output logic [PHI_W-1:0] phi_o,
   output logic             dir_o
);
   localparam logic [WK-1:0] C_E  = WK'(EIGHTH);
   localparam logic [WK-1:0] C_Q  = WK'(QUARTER);
   localparam logic [WK-1:0] C_H  = WK'(QTR);
   localparam logic [WK-1:0] C_3E = WK'(QTR - EIGHTH);

   logic ge_e, ge_q, ge_3e;
   logic [WK-1:0] phi_full;

   assign ge_e  = (t_i >= C_E);
   assign ge_q  = (t_i >= C_Q);
   assign ge_3e = (t_i >= C_3E);

   always_comb begin
      if (ge_3e)      dom_o = SLICE_3;
      else if (ge_q)  dom_o = SLICE_2;
      else if (ge_e)  dom_o = SLICE_1;
      else            dom_o = SLICE_0;
   end

   // clockwise when in the upper part of either half-quarter band
   assign dir_o = ge_3e | (ge_e & ~ge_q);

   if (PAR_FOLD) begin : g_par
      logic [WK-1:0] cand [4];
      always_comb begin
         cand[0] = t_i;
         cand[1] = C_Q - t_i;
         cand[2] = t_i - C_Q;
         cand[3] = C_H - t_i;
         phi_full = cand[dom_o];
      end
   end else begin : g_ser
      logic [WK-1:0] kbase;
      logic          rev;
      always_comb begin
         unique case (dom_o)
            SLICE_0: begin kbase = '0;  rev = 1'b0; end
            SLICE_1: begin kbase = C_Q; rev = 1'b1; end
            SLICE_2: begin kbase = C_Q; rev = 1'b0; end
            default: begin kbase = C_H; rev = 1'b1; end
         endcase
         phi_full = rev ? (kbase - t_i) : (t_i - kbase);
      end
   end

   assign phi_o = phi_full[PHI_W-1:0];

endmodule

// File: rtl/angle_fold_unit.sv
module angle_fold_unit
   import afu_pkg::*;
#(
   parameter int ANG_W    = 18,
   parameter int DAT_W    = 16,
   parameter int PHI_W    = 13,
   parameter int TURN     = 102943,
   parameter bit PAR_FOLD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [ANG_W-1:0] ang_i,
   input  logic [DAT_W-1:0]        x_i,
   input  logic [DAT_W-1:0]        y_i,
   output logic [PHI_W-1:0]        phi_o,
   output logic [1:0]              quad_o,
   output logic [1:0]              dom_o,
   output logic                    dir_o,
   output logic [DAT_W-1:0]        x_o,
   output logic [DAT_W-1:0]        y_o
);
   localparam int WK      = ANG_W + 2;
   localparam int EIGHTH  = turn_frac(TURN, 1);
   localparam int QUARTER = turn_frac(TURN, 2);
   localparam int QTR     = turn_frac(TURN, 4);

   if (EIGHTH >= (1 << PHI_W)) begin : g_chk_phi
      $error("PHI_W too narrow for the folded residue");
   end
   if (TURN >= (1 << (ANG_W - 1))) begin : g_chk_turn
      $error("ANG_W cannot hold one full turn");
   end
   if (ANG_W < 4 || DAT_W < 1) begin : g_chk_w
      $error("width parameters out of range");
   end

   logic [WK-1:0]    pos;
   logic [WK-1:0]    t_off;
   logic [1:0]       quad_c;
   slice_e           dom_c;
   logic [PHI_W-1:0] phi_c;
   logic             dir_c;

   afu_wrap #(.ANG_W(ANG_W), .WK(WK), .TURN(TURN)) u_wrap (
      .ang_i (ang_i),
      .pos_o (pos)
   );

   afu_quad #(.WK(WK), .QTR(QTR)) u_quad (
      .pos_i  (pos),
      .quad_o (quad_c),
      .t_o    (t_off)
   );

   afu_dfold #(
      .WK(WK), .PHI_W(PHI_W), .EIGHTH(EIGHTH), .QUARTER(QUARTER),
      .QTR(QTR), .PAR_FOLD(PAR_FOLD)
   ) u_dfold (
      .t_i   (t_off),
      .dom_o (dom_c),
      .phi_o (phi_c),
      .dir_o (dir_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phi_o  <= '0;
         quad_o <= '0;
         dom_o  <= '0;
         dir_o  <= 1'b0;
         x_o    <= '0;
         y_o    <= '0;
      end else begin
         phi_o  <= phi_c;
         quad_o <= quad_c;
         dom_o  <= dom_c;
         dir_o  <= dir_c;
         x_o    <= x_i;
         y_o    <= y_i;
      end
   end

endmodule

// File: rtl/afu_chk.sv
module afu_chk
   import afu_pkg::*;
#(
   parameter int ANG_W = 18,
   parameter int DAT_W = 16,
   parameter int PHI_W = 13,
   parameter int TURN  = 102943
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [ANG_W-1:0] ang_i,
   input logic [DAT_W-1:0]        x_i,
   input logic [DAT_W-1:0]        y_i,
   input logic [PHI_W-1:0]        phi_o,
   input logic [1:0]              quad_o,
   input logic [1:0]              dom_o,
   input logic                    dir_o,
   input logic [DAT_W-1:0]        x_o,
   input logic [DAT_W-1:0]        y_o
);
   localparam int EIGHTH = turn_frac(TURN, 1);
   localparam int QTR    = turn_frac(TURN, 4);

   AST_PHI_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      32'(phi_o) <= EIGHTH);  // R6

   AST_XY_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (x_o == $past(x_i) && y_o == $past(y_i)));  // R10

   AST_ZERO_ANGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ang_i) == 0) |-> (phi_o == 0 && quad_o == 0 && dom_o == 0));  // R7

   AST_FIRST_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ang_i) >= 0 && 32'($past(ang_i)) < QTR) |-> quad_o == 2'd0);  // R4

   AST_LOW_SLICE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !dom_o[0]) |-> 32'(phi_o) < EIGHTH);  // R5

   AST_HIGH_SLICE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && dom_o[0]) |-> phi_o != 0);  // R7

endmodule

bind angle_fold_unit afu_chk #(
   .ANG_W(ANG_W), .DAT_W(DAT_W), .PHI_W(PHI_W), .TURN(TURN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ang_i(ang_i), .x_i(x_i), .y_i(y_i),
   .phi_o(phi_o), .quad_o(quad_o), .dom_o(dom_o), .dir_o(dir_o),
   .x_o(x_o), .y_o(y_o)
);

// File: tb/sim_angle_fold_unit.sv
`timescale 1ns/1ps
module sim_angle_fold_unit;

   typedef struct {
      int          phi;
      int          q;
      int          d;
      int          dir;
      logic [15:0] x;
      logic [15:0] y;
      string       tag;
   } exp_t;

   logic               clk   = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [17:0] ang   = '0;
   logic [15:0]        xin   = '0;
   logic [15:0]        yin   = '0;
   logic [12:0]        phi;
   logic [1:0]         quad;
   logic [1:0]         dom;
   logic               dir;
   logic [15:0]        xout;
   logic [15:0]        yout;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   angle_fold_unit u0 (
      .clk(clk), .rst_n(rst_n), .ang_i(ang), .x_i(xin), .y_i(yin),
      .phi_o(phi), .quad_o(quad), .dom_o(dom), .dir_o(dir),
      .x_o(xout), .y_o(yout)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference fold built from the stated requirements
   function automatic exp_t model(input int a);
      exp_t e;
      int w, t;
      w = a;
      if (w < -102943)      w += 205886;
      else if (w < 0)       w += 102943;
      else if (w >= 102943) w -= 102943;
      e.q = (w >= 77208) ? 3 : (w >= 51472) ? 2 : (w >= 25736) ? 1 : 0;
      t = w - e.q * 25736;
      if (t < 6434)       begin e.d = 0; e.phi = t;          end
      else if (t < 12868) begin e.d = 1; e.phi = 12868 - t;  end
      else if (t < 19302) begin e.d = 2; e.phi = t - 12868;  end
      else                begin e.d = 3; e.phi = 25736 - t;  end
      e.dir = (e.d == 1 || e.d == 3) ? 1 : 0;
      return e;
   endfunction

   task automatic apply(input int a, input string tag);
      exp_t e;
      @(negedge clk);
      ang = 18'(a);
      xin = 16'(a * 7 + 13);
      yin = 16'(a ^ 16'h5A3C);
      e = model(a);
      e.x = xin;
      e.y = yin;
      e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: results appear at the edge after the inputs were driven (R2)
   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk({e.tag, "/R4"},  "quad", int'(quad), e.q);
         chk({e.tag, "/R5"},  "dom",  int'(dom),  e.d);
         chk({e.tag, "/R5"},  "phi",  int'(phi),  e.phi);
         chk({e.tag, "/R8"},  "dir",  int'(dir),  e.dir);
         chk({e.tag, "/R10"}, "x",    int'(xout), int'(e.x));
         chk({e.tag, "/R10"}, "y",    int'(yout), int'(e.y));
         chk({e.tag, "/R6"},  "phi_le_eighth", int'(phi <= 13'd6434), 1);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset clears outputs despite busy inputs
      ang = 18'sd30000;
      xin = 16'hBEEF;
      yin = 16'h1234;
      repeat (3) @(negedge clk);
      chk("R1", "phi",  int'(phi),  0);
      chk("R1", "quad", int'(quad), 0);
      chk("R1", "dom",  int'(dom),  0);
      chk("R1", "dir",  int'(dir),  0);
      chk("R1", "x",    int'(xout), 0);
      chk("R1", "y",    int'(yout), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 boundaries and their lower neighbours
      apply(0,     "R7");
      apply(1000,  "R5");
      apply(6433,  "R7");
      apply(6434,  "R7");
      apply(12867, "R7");
      apply(12868, "R7");
      apply(19301, "R7");
      apply(19302, "R7");
      apply(25735, "R7");
      apply(25736, "R7");
      apply(51471, "R4");
      apply(51472, "R4");
      apply(77207, "R4");
      apply(77208, "R4");
      apply(60000, "R4");
      apply(90000, "R4");
      // R3 negative angles
      apply(-1000,   "R3");
      apply(-12868,  "R3");
      apply(-25736,  "R3");
      apply(-102943, "R3");
      apply(-1,      "R3");
      // R9 out-of-range wrap
      apply(102943,  "R9");
      apply(131071,  "R9");
      apply(-102944, "R9");
      apply(-131072, "R9");
      // sweep across the whole input range
      for (int a = -131072; a < 131072; a += 1237)
         apply(a, "R5");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule